// File: doc/BRIEF.md
# I2C Serial EEPROM Target Engine

This block is a synchronous I2C target that behaves like a 2048 x 8 serial EEPROM. The block's system clock oversamples the SCL and SDA lines. The block drives the bus only through an open-drain pull-down enable, `sda_oe`, which is 1 to pull SDA low. It watches for bus START and STOP conditions and checks the fixed device code in the address byte. For reads it ignores the three page bits of the address byte. For writes it takes those three bits as bits 10..8 of the memory address, and the following word byte supplies bits 7..0. A master can use this to write single bytes or a short burst inside one 16-byte line. It can also read at the current pointer, set a pointer and then read (a random read), and continue a read in sequence for as long as it acknowledges.

Written bytes are held in a 16-slot line buffer. Nothing reaches the array until a STOP closes the transfer. The commit unit then sweeps the slots in ascending order, writes each filled slot into the register array, and reports it on the commit port. A START that interrupts a transfer throws away any staged bytes and begins decoding a new address byte.

Controller states and their transitions:
- IDLE goes to DEV on START.
- DEV goes to DEV_ACK on a matched eighth bit, or to WAIT_STOP on a wrong device code.
- DEV_ACK goes to WADDR in write mode, or to RDATA in read mode.
- WADDR goes to WADDR_ACK.
- WADDR_ACK goes to WDATA.
- WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA.
- RDATA goes to RACK after eight bits.
- RACK goes to RDATA on a master ACK, or to WAIT_STOP on a NACK.
- From any state, START goes to DEV and STOP goes to IDLE.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After reset, before any START, clocked bytes get no ACK.
- R2: Only an address byte whose bits 7..4 equal 1010 gets an ACK. With any other code, the block stays off the bus until a STOP.
- R3: The block pulls SDA low for the whole ninth SCL clock after a matched address byte and after each received word-address or data byte. It releases SDA after that clock's falling edge.
- R4: A write-mode address byte (bit 0 = 0) supplies memory address bits 10..8 from its bits 3..1. The next byte supplies address bits 7..0.
- R5: Input bits are taken on the SCL rising edge, most significant bit first. Output bits change only after an SCL falling edge.
- R6: Written bytes reach memory only after a STOP. A START before the STOP discards them.
- R7: In a burst write, only the low 4 address bits advance, wrapping inside the 16-byte line. A later byte aimed at an already filled slot replaces it.
- R8: After a STOP that closes a write, `commit_we` pulses once for each staged byte. Slots are committed in ascending order, and each pulse carries that byte's address and data.
- R9: In a read, a master ACK (SDA low on the ninth clock) starts the next byte. A NACK makes the block release SDA and stay off the bus until a STOP.
- R10: After a read, the pointer is one past the last byte sent, and it wraps from 0x7FF to 0x000. After a write, the pointer is the last written address. A read-mode address byte's page bits are ignored.
- R11: A START in the middle of a byte aborts the transfer and restarts address decoding.
- R12: `sda_oe` is 0 after reset and whenever the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level (as seen on the bus) |
| sda_oe | output | 1 | 1 pulls SDA low |
| commit_we | output | 1 | One-cycle pulse per byte committed to memory |
| commit_addr | output | 11 | Address of the committed byte |
| commit_data | output | 8 | Data of the committed byte |

## Verification
Each SCL or SDA edge passes through two synchronizer flops. The event it produces is registered by the controller, so `sda_oe` changes on the third system clock after the SCL falling edge that causes it. The bench therefore samples the bus in the middle of each SCL high phase, well after that point.

A STOP is recognized two clocks after SDA rises. The commit sweep starts one clock later and takes one cycle per slot. The bench waits more than that sweep after every STOP that closes a write before it reads the commit log or starts a read.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP
    } eep_state_t;

endpackage

// File: rtl/eep_line_sync.sv
// Synchronizes SCL and SDA, then derives one-cycle bus events.
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_lvl
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_d;

    assign raw = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            if (STAGES == 1) begin : g_one
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain <= '1;
                    else        chain <= raw[g];
                end
            end else begin : g_many
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain <= '1;
                    else        chain <= {chain[STAGES-2:0], raw[g]};
                end
            end
            assign lvl[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= '1;
        else        lvl_d <= lvl;
    end

    assign scl_rise  =  lvl[0] & ~lvl_d[0];
    assign scl_fall  = ~lvl[0] &  lvl_d[0];
    assign start_evt =  lvl[0] &  lvl_d[0] &  lvl_d[1] & ~lvl[1];
    assign stop_evt  =  lvl[0] &  lvl_d[0] & ~lvl_d[1] &  lvl[1];
    assign sda_lvl   =  lvl[1];

endmodule

// File: rtl/eep_commit_store.sv
// Line staging buffer, commit sweep and the byte array.
module eep_commit_store #(
    parameter int ADDR_W = 11,
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    input  logic              buf_clr,
    input  logic              commit_go,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              commit_we,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [7:0]        commit_data,
    output logic              busy
);
    localparam int SLOTS = 1 << LINE_W;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int UP_W  = ADDR_W - LINE_W;

    logic [7:0]        mem       [DEPTH];
    logic [7:0]        slot_data [SLOTS];
    logic [SLOTS-1:0]  slot_vld;
    logic [UP_W-1:0]   line_q;
    logic [LINE_W-1:0] idx_q;
    logic              busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_vld <= '0;
            line_q   <= '0;
            idx_q    <= '0;
            busy_q   <= 1'b0;
        end else if (busy_q) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == {LINE_W{1'b1}}) begin
                busy_q   <= 1'b0;
                slot_vld <= '0;
            end
        end else if (commit_go && |slot_vld) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (buf_clr) begin
            slot_vld <= '0;
        end else if (buf_we) begin
            slot_vld[buf_addr[LINE_W-1:0]] <= 1'b1;
            line_q <= buf_addr[ADDR_W-1:LINE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we && !busy_q) slot_data[buf_addr[LINE_W-1:0]] <= buf_data;
    end

    assign commit_we   = busy_q & slot_vld[idx_q];
    assign commit_addr = {line_q, idx_q};
    assign commit_data = slot_data[idx_q];
    assign busy        = busy_q;

    always_ff @(posedge clk) begin
        if (commit_we) mem[commit_addr] <= commit_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eep_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter int         LINE_W      = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              commit_we,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [7:0]        commit_data
);
    localparam int PAGE_W = ADDR_W - 8;

    eep_state_t        state_q, state_d;
    logic              scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;
    logic [7:0]        rx_sr, tx_sr, rd_data;
    logic [3:0]        rx_cnt;
    logic [2:0]        tx_cnt;
    logic              rd_mode, mack, store_busy;
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] ptr_q, wr_next;
    logic              rx_full, byte_end, dev_match, buf_we;

    eep_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl)
    );

    assign rx_full   = (rx_cnt == 4'd8);
    assign byte_end  = scl_fall && rx_full;
    assign dev_match = (rx_sr[7:4] == DEV_CODE);
    assign buf_we    = (state_q == ST_WDATA) && byte_end && !start_evt
                       && !stop_evt && !store_busy;

    eep_commit_store #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .buf_we(buf_we), .buf_addr(wr_next), .buf_data(rx_sr),
        .buf_clr(start_evt), .commit_go(stop_evt),
        .rd_addr(ptr_q), .rd_data(rd_data),
        .commit_we(commit_we), .commit_addr(commit_addr),
        .commit_data(commit_data), .busy(store_busy)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (start_evt) begin
            state_d = ST_DEV;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEV:       if (byte_end) state_d = dev_match ? ST_DEV_ACK : ST_WAIT_STOP;
                ST_DEV_ACK:   if (scl_fall) state_d = rd_mode ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_end) state_d = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_end) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && tx_cnt == 3'd7) state_d = ST_RACK;
                ST_RACK:      if (scl_fall) state_d = mack ? ST_RDATA : ST_WAIT_STOP;
                ST_WAIT_STOP: state_d = ST_WAIT_STOP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            rx_sr   <= '0;
            rx_cnt  <= '0;
            tx_sr   <= '0;
            tx_cnt  <= '0;
            rd_mode <= 1'b0;
            mack    <= 1'b0;
            page_q  <= '0;
            ptr_q   <= '0;
            wr_next <= '0;
        end else if (start_evt) begin
            sda_oe <= 1'b0;
            rx_cnt <= '0;
            tx_cnt <= '0;
        end else if (stop_evt) begin
            sda_oe <= 1'b0;
            rx_cnt <= '0;
        end else begin
            unique case (state_q)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && !rx_full) begin
                        rx_sr  <= {rx_sr[6:0], sda_lvl};
                        rx_cnt <= rx_cnt + 4'd1;
                    end
                    if (byte_end) begin
                        rx_cnt <= '0;
                        if (state_q == ST_DEV) begin
                            if (dev_match) begin
                                sda_oe  <= 1'b1;
                                rd_mode <= rx_sr[0];
                                if (!rx_sr[0]) page_q <= rx_sr[PAGE_W:1];
                            end
                        end else if (state_q == ST_WADDR) begin
                            sda_oe  <= 1'b1;
                            ptr_q   <= {page_q, rx_sr};
                            wr_next <= {page_q, rx_sr};
                        end else if (!store_busy) begin
                            sda_oe <= 1'b1;
                            ptr_q  <= wr_next;
                            wr_next[LINE_W-1:0] <= wr_next[LINE_W-1:0] + 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (rd_mode) begin
                            tx_sr  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr_q  <= ptr_q + 1'b1;
                            tx_cnt <= '0;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) sda_oe <= 1'b0;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (tx_cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                        end else begin
                            tx_sr  <= {tx_sr[6:0], 1'b0};
                            sda_oe <= ~tx_sr[6];
                        end
                        tx_cnt <= tx_cnt + 3'd1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack <= ~sda_lvl;
                    if (scl_fall && mack) begin
                        tx_sr  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr_q  <= ptr_q + 1'b1;
                        tx_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/eep_i2c_checker.sv
module eep_i2c_checker
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input eep_state_t state_q,
    input logic       sda_oe,
    input logic       scl_fall,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       store_busy
);

    p_oe_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);

    p_master_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RACK) |-> !sda_oe);

    p_wait_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_STOP) |-> !sda_oe);

    p_ack_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK || state_q == ST_WADDR_ACK || state_q == ST_WDATA_ACK)
        |-> sda_oe);

    p_commit_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_busy) |-> $past(stop_evt));

endmodule

bind eeprom_i2c_target eep_i2c_checker chk_i (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .sda_oe(sda_oe),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .store_busy(store_busy)
);

// File: tb/eeprom_i2c_target_tb_top.sv
module eeprom_i2c_target_tb_top;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, commit_we;
    logic [10:0] commit_addr;
    logic [7:0]  commit_data;

    int checks = 0;
    int fails  = 0;
    int ccount = 0;
    logic [10:0] log_a [32];
    logic [7:0]  log_d [32];

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    eeprom_i2c_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .commit_we(commit_we),
        .commit_addr(commit_addr), .commit_data(commit_data)
    );

    always @(negedge clk) begin
        if (rst_n && commit_we) begin
            if (ccount < 32) begin
                log_a[ccount] = commit_addr;
                log_d[ccount] = commit_data;
            end
            ccount++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(5);
        scl_m = 1'b1; tick(10);
        sda_m = 1'b0; tick(10);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(5);
        scl_m = 1'b1; tick(10);
        sda_m = 1'b1; tick(30);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(5);
        scl_m = 1'b1; tick(HALF);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(5);
        scl_m = 1'b1; tick(10);
        acked = ~sda_line;
        tick(10);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(5);
            scl_m = 1'b1; tick(10);
            b[i] = sda_line;
            tick(10);
            scl_m = 1'b0; tick(5);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(5);
        scl_m = 1'b1; tick(HALF);
        scl_m = 1'b0; tick(3);
        sda_m = 1'b1; tick(2);
    endtask

    task automatic byte_write(input logic [10:0] a, input logic [7:0] d);
        logic ak;
        bus_start();
        send_byte({4'b1010, a[10:8], 1'b0}, ak);
        send_byte(a[7:0], ak);
        send_byte(d, ak);
        bus_stop();
        tick(30);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] rd;
        int base;
        tick(4);
        chk("R12 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);
        chk("R12 oe after reset", sda_oe, 0);

        // R1: a byte without START gets no ACK
        send_byte(8'hA0, ak);
        chk("R1 no start no ack", ak, 0);

        // R2: wrong device code, then silence until STOP
        bus_start();
        send_byte(8'hB0, ak);
        chk("R2 wrong code no ack", ak, 0);
        send_byte(8'h00, ak);
        chk("R2 silent until stop", ak, 0);
        bus_stop();

        // R3 R4 R6 R8: byte write at 0x534
        bus_start();
        send_byte(8'hAA, ak);
        chk("R3 ack address", ak, 1);
        send_byte(8'h34, ak);
        chk("R3 ack word address", ak, 1);
        send_byte(8'h5C, ak);
        chk("R3 ack data", ak, 1);
        tick(40);
        chk("R6 no commit before stop", ccount, 0);
        bus_stop();
        tick(30);
        chk("R8 one commit", ccount, 1);
        chk("R4 commit address", log_a[0], 11'h534);
        chk("R8 commit data", log_d[0], 8'h5C);

        // R10: current read after a write returns the last written byte
        bus_start();
        send_byte(8'hA1, ak);
        chk("R3 ack read address", ak, 1);
        recv_byte(1'b0, rd);
        chk("R10 R5 current read after write", rd, 8'h5C);
        bus_stop();

        // R7 R8: burst wraps inside the line
        base = ccount;
        bus_start();
        send_byte(8'hA2, ak);
        send_byte(8'hFE, ak);
        send_byte(8'h11, ak);
        send_byte(8'h22, ak);
        send_byte(8'h33, ak);
        chk("R3 ack third burst byte", ak, 1);
        bus_stop();
        tick(30);
        chk("R8 burst commit count", ccount - base, 3);
        chk("R7 wrapped slot first addr", log_a[base], 11'h1F0);
        chk("R7 wrapped slot first data", log_d[base], 8'h33);
        chk("R8 ascending last addr", log_a[base + 2], 11'h1FF);
        chk("R8 ascending last data", log_d[base + 2], 8'h22);

        // R7: repeated slot replaces the earlier byte
        base = ccount;
        bus_start();
        send_byte(8'hA6, ak);
        send_byte(8'h4F, ak);
        for (int k = 0; k < 17; k++) send_byte(8'(k + 8'h60), ak);
        bus_stop();
        tick(30);
        chk("R7 full line count", ccount - base, 16);
        chk("R7 overwritten slot data", log_d[base + 15], 8'h70);
        chk("R7 overwritten slot addr", log_a[base + 15], 11'h34F);

        byte_write(11'h200, 8'h44);
        byte_write(11'h201, 8'h45);

        // R9 R10: random read then sequential across the line
        bus_start();
        send_byte(8'hA2, ak);
        send_byte(8'hFE, ak);
        bus_start();
        send_byte(8'hA7, ak);
        chk("R10 read with page bits ack", ak, 1);
        recv_byte(1'b1, rd);
        chk("R10 random read first", rd, 8'h11);
        recv_byte(1'b1, rd);
        chk("R9 continue after ack", rd, 8'h22);
        recv_byte(1'b0, rd);
        chk("R10 sequential next line", rd, 8'h44);
        bus_stop();
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, rd);
        chk("R10 current read after read", rd, 8'h45);
        bus_stop();

        // R10: wrap from top of array
        byte_write(11'h7FF, 8'hE1);
        byte_write(11'h000, 8'hE2);
        bus_start();
        send_byte(8'hAE, ak);
        send_byte(8'hFF, ak);
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b1, rd);
        chk("R10 top byte", rd, 8'hE1);
        recv_byte(1'b0, rd);
        chk("R10 wrap to zero", rd, 8'hE2);

        // R9: after NACK the line stays released
        begin
            int lows = 0;
            for (int k = 0; k < 9; k++) begin
                tick(5);
                scl_m = 1'b1; tick(10);
                if (!sda_line) lows++;
                tick(10);
                scl_m = 1'b0; tick(5);
            end
            chk("R9 released after nack", lows, 0);
        end
        bus_stop();

        // R11 R6: START mid-byte aborts and discards staged data
        base = ccount;
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h10, ak);
        send_byte(8'h99, ak);
        for (int k = 0; k < 4; k++) send_bit(1'b0);
        bus_start();
        send_byte(8'hA0, ak);
        chk("R11 restart decodes address", ak, 1);
        bus_stop();
        tick(30);
        chk("R6 aborted write discarded", ccount - base, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule